// File: doc/BRIEF.md
# Flash byte-program sequencer with status-bit polling

This block writes a run of bytes into a 5 V parallel flash device on behalf of a host. After a start pulse it takes a base address and a byte count. For each byte it asks the user for data with a one-cycle request. It then drives the device through two unlock writes, a program command write and the data write. After the last write pulse ends it polls the status bit on DQ7. When that bit shows the written bit 7, the embedded program has finished. A separate read follows and the whole byte is compared. The address then advances until the count is used up.

Each bus access has a fixed shape: one setup cycle, a strobe phase and one hold cycle. The write strobe lasts `T_WP` clocks and the read strobe lasts `T_OE` clocks. Read data is captured once per access, on the last clock of the read strobe. A run ends in one of three ways: a done pulse, a timeout error if the status bit never matches within `MAX_POLLS` polls, or a verify error that reports the failing address.

Top module: `flash_prog_seq`

## Requirements
- R1: Each byte is programmed with exactly four writes in this order: (0x5555, 0xAA), (0x2AAA, 0x55), (0x5555, 0xA0), then (target address, data byte).
- R2: Every write holds WE# low for exactly `T_WP` clocks, with CE# low, OE# high, and address and data stable while WE# is low. WE# and OE# are never low together.
- R3: No read of the device occurs between the first and the fourth write of a byte. Each poll or verify is a separate access with its own OE# assertion, lasting `T_OE` clocks. DQ is sampled only on the last clock of that strobe. The data bus is not driven while OE# is low.
- R4: A poll whose DQ7 differs from bit 7 of the written byte (the complement) causes another poll. A poll whose DQ7 equals it ends polling, even if DQ0–DQ6 are wrong in that read.
- R5: After polling ends, one more read is made and all 8 bits are compared with the written byte. On a mismatch the run stops with `err_o`=1, `err_code_o`=2'b10 and `err_addr_o` set to the target address.
- R6: If `MAX_POLLS` consecutive polls all show the complement, the run stops with `err_o`=1, `err_code_o`=2'b01 and `err_addr_o` set to the target address, after exactly `MAX_POLLS` reads.
- R7: Bytes go to `base_addr_i`, `base_addr_i`+1, and so on, for `length_i` bytes. `data_req_o` pulses once per byte, and `data_i` is taken in that same cycle.
- R8: `busy_o` is high from the cycle after an accepted start until the run ends. `done_o` is a one-cycle pulse at a successful end. A start with `length_i`=0 gives `done_o` on the next cycle, with no bus access.
- R9: `err_o` and `err_code_o` hold until the next accepted start, which clears them. A start pulse while busy is ignored.
- R10: In reset, CE#, WE# and OE# are high, the data bus is not driven, and `busy_o`, `done_o` and `err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted when idle |
| base_addr_i | input | ADDR_W | First target address |
| length_i | input | LEN_W | Number of bytes to program |
| data_i | input | 8 | Next byte, valid in the cycle `data_req_o` is high |
| data_req_o | output | 1 | Request for the next data byte |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse on successful completion |
| err_o | output | 1 | Run ended in error (level) |
| err_code_o | output | 2 | 2'b01 poll timeout, 2'b10 verify mismatch |
| err_addr_o | output | ADDR_W | Address of the failing byte |
| fl_addr_o | output | ADDR_W | Flash address |
| fl_dq_o | output | 8 | Flash write data |
| fl_dq_oe_o | output | 1 | Drive enable for the flash data bus |
| fl_dq_i | input | 8 | Flash read data |
| fl_we_no | output | 1 | Write enable, active low |
| fl_oe_no | output | 1 | Output enable, active low |
| fl_ce_no | output | 1 | Chip enable, active low |

## Verification
The hardest case to reach is the read in which DQ7 has just turned true but the lower bits still hold stale values. A controller that compares that same read instead of making a fresh one only fails in this case. The bench's device model serves every poll from a small state machine. While busy it returns the complement of bit 7. On the first completed read it returns the true bit 7 with DQ0–DQ6 inverted, and only later reads return the stored byte. The model's busy-poll count is set per run, including zero, and each run checks the exact number of reads per byte. Timeout and verify-failure runs come from a model that never completes, and from one that flips a bit of a chosen stored byte.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;
  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_WR, S_POLL, S_VER, S_NEXT} seq_st_e;
  typedef enum logic [1:0] {B_IDLE, B_SETUP, B_ACT, B_HOLD} bus_st_e;
  typedef enum logic [1:0] {ERR_NONE = 2'b00, ERR_TIMEOUT = 2'b01, ERR_VERIFY = 2'b10} err_e;

  localparam logic [14:0] UNLOCK_ADDR1 = 15'h5555;
  localparam logic [14:0] UNLOCK_ADDR2 = 15'h2AAA;
  localparam logic [7:0]  UNLOCK_DATA1 = 8'hAA;
  localparam logic [7:0]  UNLOCK_DATA2 = 8'h55;
  localparam logic [7:0]  PROG_CMD     = 8'hA0;
endpackage

// File: rtl/flash_bus_cycle.sv
module flash_bus_cycle
  import flash_prog_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int T_WP   = 3,
  parameter int T_OE   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic              done_o,
  output logic [7:0]        rdata_o,
  output logic [ADDR_W-1:0] fl_addr_o,
  output logic [7:0]        fl_dq_o,
  output logic              fl_dq_oe_o,
  input  logic [7:0]        fl_dq_i,
  output logic              fl_we_no,
  output logic              fl_oe_no,
  output logic              fl_ce_no
);
  localparam int TMAX = (T_WP > T_OE) ? T_WP : T_OE;
  localparam int CW   = $clog2(TMAX + 1);
  localparam logic [CW-1:0] WP_LAST = CW'(T_WP - 1);
  localparam logic [CW-1:0] OE_LAST = CW'(T_OE - 1);

  bus_st_e           st_q;
  logic [CW-1:0]     cnt_q;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        wdata_q, rdata_q;
  logic              act_end;

  assign act_end = (st_q == B_ACT) && (cnt_q == (wr_q ? WP_LAST : OE_LAST));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= B_IDLE;
      cnt_q   <= '0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      unique case (st_q)
        B_IDLE: if (go_i) begin
          wr_q    <= wr_i;
          addr_q  <= addr_i;
          wdata_q <= wdata_i;
          st_q    <= B_SETUP;
        end
        B_SETUP: begin
          cnt_q <= '0;
          st_q  <= B_ACT;
        end
        B_ACT: if (act_end) begin
          st_q <= B_HOLD;
          // single defined sample point: last strobe clock
          if (!wr_q) rdata_q <= fl_dq_i;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        B_HOLD:  st_q <= B_IDLE;
        default: st_q <= B_IDLE;
      endcase
    end
  end

  assign done_o     = (st_q == B_HOLD);
  assign rdata_o    = rdata_q;
  assign fl_addr_o  = addr_q;
  assign fl_dq_o    = wdata_q;
  assign fl_dq_oe_o = wr_q && (st_q != B_IDLE);
  assign fl_ce_no   = (st_q == B_IDLE);
  assign fl_we_no   = !((st_q == B_ACT) && wr_q);
  assign fl_oe_no   = !((st_q == B_ACT) && !wr_q);
endmodule

// File: rtl/flash_addr_ctr.sv
module flash_addr_ctr #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      rem_q  <= '0;
    end else if (load_i) begin
      addr_q <= base_i;
      rem_q  <= len_i;
    end else if (step_i) begin
      addr_q <= addr_q + 1'b1;
      rem_q  <= rem_q - 1'b1;
    end
  end

  assign addr_o = addr_q;
  assign last_o = (rem_q == LEN_W'(1));
endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import flash_prog_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int LEN_W     = 8,
  parameter int T_WP      = 3,
  parameter int T_OE      = 4,
  parameter int MAX_POLLS = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [LEN_W-1:0]  length_i,
  input  logic [7:0]        data_i,
  output logic              data_req_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [1:0]        err_code_o,
  output logic [ADDR_W-1:0] err_addr_o,
  output logic [ADDR_W-1:0] fl_addr_o,
  output logic [7:0]        fl_dq_o,
  output logic              fl_dq_oe_o,
  input  logic [7:0]        fl_dq_i,
  output logic              fl_we_no,
  output logic              fl_oe_no,
  output logic              fl_ce_no
);
  localparam int PW = $clog2(MAX_POLLS + 1);
  localparam logic [PW-1:0] POLL_LAST = PW'(MAX_POLLS - 1);

  seq_st_e           state_q;
  logic [7:0]        data_q;
  logic [1:0]        wr_idx_q;
  logic [PW-1:0]     poll_q;
  logic              go_q, done_q, err_q;
  err_e              err_code_q;
  logic [ADDR_W-1:0] err_addr_q;

  logic              cyc_done, cyc_wr, ctr_load, ctr_step, ctr_last;
  logic [7:0]        cyc_rdata, cyc_wdata;
  logic [ADDR_W-1:0] cyc_addr, tgt_addr;

  assign ctr_load = (state_q == S_IDLE) && start_i && (length_i != '0);
  assign ctr_step = (state_q == S_NEXT) && !ctr_last;
  assign cyc_wr   = (state_q == S_WR);

  always_comb begin
    cyc_addr  = tgt_addr;
    cyc_wdata = data_q;
    if (cyc_wr) begin
      unique case (wr_idx_q)
        2'd0: begin cyc_addr = ADDR_W'(UNLOCK_ADDR1); cyc_wdata = UNLOCK_DATA1; end
        2'd1: begin cyc_addr = ADDR_W'(UNLOCK_ADDR2); cyc_wdata = UNLOCK_DATA2; end
        2'd2: begin cyc_addr = ADDR_W'(UNLOCK_ADDR1); cyc_wdata = PROG_CMD;     end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      data_q     <= '0;
      wr_idx_q   <= '0;
      poll_q     <= '0;
      go_q       <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      err_code_q <= ERR_NONE;
      err_addr_q <= '0;
    end else begin
      go_q   <= 1'b0;
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          err_q      <= 1'b0;
          err_code_q <= ERR_NONE;
          if (length_i == '0) done_q <= 1'b1;
          else                state_q <= S_FETCH;
        end
        S_FETCH: begin
          data_q   <= data_i;
          wr_idx_q <= '0;
          go_q     <= 1'b1;
          state_q  <= S_WR;
        end
        S_WR: if (cyc_done) begin
          go_q <= 1'b1;
          if (wr_idx_q == 2'd3) begin
            poll_q  <= '0;
            state_q <= S_POLL;
          end else begin
            wr_idx_q <= wr_idx_q + 1'b1;
          end
        end
        S_POLL: if (cyc_done) begin
          if (cyc_rdata[7] == data_q[7]) begin
            go_q    <= 1'b1;
            state_q <= S_VER;
          end else if (poll_q == POLL_LAST) begin
            err_q      <= 1'b1;
            err_code_q <= ERR_TIMEOUT;
            err_addr_q <= tgt_addr;
            state_q    <= S_IDLE;
          end else begin
            poll_q <= poll_q + 1'b1;
            go_q   <= 1'b1;
          end
        end
        S_VER: if (cyc_done) begin
          if (cyc_rdata == data_q) begin
            state_q <= S_NEXT;
          end else begin
            err_q      <= 1'b1;
            err_code_q <= ERR_VERIFY;
            err_addr_q <= tgt_addr;
            state_q    <= S_IDLE;
          end
        end
        S_NEXT: begin
          if (ctr_last) begin
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            state_q <= S_FETCH;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  flash_addr_ctr #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (ctr_load),
    .base_i (base_addr_i),
    .len_i  (length_i),
    .step_i (ctr_step),
    .addr_o (tgt_addr),
    .last_o (ctr_last)
  );

  flash_bus_cycle #(.ADDR_W(ADDR_W), .T_WP(T_WP), .T_OE(T_OE)) u_bus (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .go_i       (go_q),
    .wr_i       (cyc_wr),
    .addr_i     (cyc_addr),
    .wdata_i    (cyc_wdata),
    .done_o     (cyc_done),
    .rdata_o    (cyc_rdata),
    .fl_addr_o  (fl_addr_o),
    .fl_dq_o    (fl_dq_o),
    .fl_dq_oe_o (fl_dq_oe_o),
    .fl_dq_i    (fl_dq_i),
    .fl_we_no   (fl_we_no),
    .fl_oe_no   (fl_oe_no),
    .fl_ce_no   (fl_ce_no)
  );

  assign data_req_o = (state_q == S_FETCH);
  assign busy_o     = (state_q != S_IDLE);
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign err_code_o = err_code_q;
  assign err_addr_o = err_addr_q;
endmodule

// File: rtl/flash_prog_seq_chk.sv
module flash_prog_seq_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              data_req_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic [ADDR_W-1:0] fl_addr_o,
  input logic [7:0]        fl_dq_o,
  input logic              fl_dq_oe_o,
  input logic              fl_we_no,
  input logic              fl_oe_no,
  input logic              fl_ce_no
);
  // R2
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!fl_we_no && !fl_oe_no));

  // R2
  ce_cover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fl_we_no || !fl_oe_no) |-> !fl_ce_no);

  // R2
  wr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fl_we_no && $past(!fl_we_no)) |-> ($stable(fl_addr_o) && $stable(fl_dq_o)));

  // R3
  no_contend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_dq_oe_o |-> fl_oe_no);

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R9
  err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !start_i) |=> err_o);

  // R7
  req_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_req_o |-> busy_o);

  // R10
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      rst_idle_chk: assert (fl_ce_no && fl_we_no && fl_oe_no && !busy_o && !done_o && !err_o);
    end
  end
endmodule

bind flash_prog_seq flash_prog_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .data_req_o (data_req_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .err_o      (err_o),
  .fl_addr_o  (fl_addr_o),
  .fl_dq_o    (fl_dq_o),
  .fl_dq_oe_o (fl_dq_oe_o),
  .fl_we_no   (fl_we_no),
  .fl_oe_no   (fl_oe_no),
  .fl_ce_no   (fl_ce_no)
);

// File: tb/flash_prog_seq_test.sv
`timescale 1ns/1ps
module flash_prog_seq_test;
  localparam int AW = 16, LW = 8, TWP = 3, TOE = 4, MAXP = 32;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] base = '0;
  logic [LW-1:0] len = '0;
  logic [7:0]    data_in;
  logic          data_req, busy, done, err;
  logic [1:0]    err_code;
  logic [AW-1:0] err_addr, fl_addr;
  logic [7:0]    fl_dq_out, fl_dq_in;
  logic          fl_dq_oe, fl_we_n, fl_oe_n, fl_ce_n;

  int n_vec = 0, n_miss = 0;

  always #2 clk = ~clk;

  flash_prog_seq #(.ADDR_W(AW), .LEN_W(LW), .T_WP(TWP), .T_OE(TOE), .MAX_POLLS(MAXP)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .base_addr_i(base), .length_i(len),
    .data_i(data_in), .data_req_o(data_req), .busy_o(busy), .done_o(done), .err_o(err),
    .err_code_o(err_code), .err_addr_o(err_addr), .fl_addr_o(fl_addr), .fl_dq_o(fl_dq_out),
    .fl_dq_oe_o(fl_dq_oe), .fl_dq_i(fl_dq_in), .fl_we_no(fl_we_n), .fl_oe_no(fl_oe_n),
    .fl_ce_no(fl_ce_n)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_miss++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // data source
  logic [7:0] src [256];
  int req_total = 0, req_base = 0;
  always @(posedge clk) if (data_req) req_total <= req_total + 1;
  assign data_in = src[8'(req_total - req_base)];

  // scoreboard queue of expected {addr, data} program writes
  logic [23:0] exp_q [$];

  // flash device model
  logic [7:0] fmem [256];
  int   step = 0, busy_left = 0, mode = 0;
  int   rd_cnt = 0, wr_cnt = 0, prog_cnt = 0, proto_err = 0, wp_viol = 0, we_low = 0;
  int   busy_cfg = 0;
  bit   pend = 0, we_q = 1, oe_q = 1, clr_req = 0, corrupt_en = 0;
  logic [AW-1:0] corrupt_addr = '0;
  logic [7:0] pd = '0;

  always @(posedge clk) begin
    we_q <= fl_we_n;
    oe_q <= fl_oe_n;
    if (clr_req) begin
      step <= 0; pend <= 0; mode <= 0; rd_cnt <= 0; wr_cnt <= 0;
      prog_cnt <= 0; proto_err <= 0; wp_viol <= 0; we_low <= 0;
    end else begin
      if (!fl_we_n) we_low <= we_low + 1;
      if (!we_q && fl_we_n) begin
        we_low <= 0;
        wr_cnt <= wr_cnt + 1;
        if (fl_ce_n || !fl_oe_n) proto_err <= proto_err + 1;
        if (we_low != TWP) wp_viol <= wp_viol + 1;
        if (pend) proto_err <= proto_err + 1;
        case (step)
          0: if (fl_addr == 16'h5555 && fl_dq_out == 8'hAA) step <= 1;
             else begin proto_err <= proto_err + 1; step <= 0; end
          1: if (fl_addr == 16'h2AAA && fl_dq_out == 8'h55) step <= 2;
             else begin proto_err <= proto_err + 1; step <= 0; end
          2: if (fl_addr == 16'h5555 && fl_dq_out == 8'hA0) step <= 3;
             else begin proto_err <= proto_err + 1; step <= 0; end
          default: begin
            // monitor: compare the committed program write with the scoreboard
            if (exp_q.size() == 0) begin
              chk(1'b0, "R7 unexpected program write", {fl_addr, fl_dq_out}, 0);
            end else begin
              logic [23:0] e;
              e = exp_q.pop_front();
              chk(e == {fl_addr, fl_dq_out}, "R1 program write addr/data", {fl_addr, fl_dq_out}, e);
            end
            fmem[fl_addr[7:0]] <= (corrupt_en && fl_addr == corrupt_addr) ? (fl_dq_out ^ 8'h01) : fl_dq_out;
            pd        <= fl_dq_out;
            pend      <= 1;
            busy_left <= busy_cfg;
            prog_cnt  <= prog_cnt + 1;
            step      <= 0;
          end
        endcase
      end
      if (oe_q && !fl_oe_n) begin
        rd_cnt <= rd_cnt + 1;
        if (step != 0) proto_err <= proto_err + 1;
        if (pend) begin
          if (busy_left > 0) begin busy_left <= busy_left - 1; mode <= 1; end
          else begin mode <= 2; pend <= 0; end
        end else mode <= 0;
      end
    end
  end

  always_comb begin
    case (mode)
      1:       fl_dq_in = {~pd[7], 7'h2A};
      2:       fl_dq_in = {pd[7], ~pd[6:0]};
      default: fl_dq_in = fmem[fl_addr[7:0]];
    endcase
  end

  task automatic clear_model();
    @(negedge clk) clr_req = 1;
    @(negedge clk) clr_req = 0;
  endtask

  bit err_after_start = 0;

  task automatic run(input logic [AW-1:0] b, input logic [LW-1:0] n, input int npush, output int cycles);
    req_base = req_total;
    for (int i = 0; i < npush; i++) exp_q.push_back({16'(b + 16'(i)), src[i]});
    @(negedge clk);
    start = 1; base = b; len = n;
    @(negedge clk);
    start = 0;
    err_after_start = err;
    cycles = 1;
    while (!done && !err && cycles < 20000) begin
      @(negedge clk);
      cycles++;
    end
    chk(cycles < 20000, "R8 run did not end", cycles, 20000);
  endtask

  initial begin
    #(200000 * 4);
    n_miss++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end

  initial begin
    int cyc;
    for (int i = 0; i < 256; i++) fmem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(fl_ce_n && fl_we_n && fl_oe_n && !fl_dq_oe, "R10 strobes idle in reset",
        {fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe}, 4'b1110);
    chk(!busy && !done && !err, "R10 status low in reset", {busy, done, err}, 0);
    rst_n = 1;
    clear_model();

    // T1: 4 bytes, 3 busy polls each
    for (int i = 0; i < 256; i++) src[i] = 8'(i * 37 + 5);
    busy_cfg = 3;
    run(16'h1010, 8'd4, 4, cyc);
    chk(!err, "R7 no error on clean run", err, 0);
    for (int i = 0; i < 4; i++)
      chk(fmem[8'h10 + i] == src[i], "R7 stored byte", fmem[8'h10 + i], src[i]);
    chk(proto_err == 0, "R1 command sequence order", proto_err, 0);
    chk(wp_viol == 0, "R2 write pulse width", wp_viol, 0);
    chk(rd_cnt == 4 * (3 + 2), "R3 reads per byte with busy polls", rd_cnt, 20);
    chk(req_total - req_base == 4, "R7 data requests", req_total - req_base, 4);
    chk(exp_q.size() == 0, "R7 all expected writes seen", exp_q.size(), 0);
    clear_model();

    // T2: DQ7 true at first poll, low bits stale in that read
    for (int i = 0; i < 256; i++) src[i] = 8'(i * 91 + 200);
    busy_cfg = 0;
    run(16'h10F0, 8'd3, 3, cyc);
    chk(!err, "R4 stale low bits do not fail a byte", err_code, 0);
    chk(rd_cnt == 3 * 2, "R5 separate verify read", rd_cnt, 6);
    for (int i = 0; i < 3; i++)
      chk(fmem[8'hF0 + i] == src[i], "R4 stored byte", fmem[8'hF0 + i], src[i]);
    clear_model();

    // T3: zero length
    run(16'h1000, 8'd0, 0, cyc);
    chk(done && cyc == 1, "R8 zero length completes at once", cyc, 1);
    chk(wr_cnt == 0 && rd_cnt == 0, "R8 zero length no bus access", wr_cnt + rd_cnt, 0);
    @(negedge clk);
    chk(!done, "R8 done is one cycle", done, 0);
    clear_model();

    // T4: verify mismatch on third byte
    for (int i = 0; i < 256; i++) src[i] = 8'(i * 53 + 17);
    busy_cfg = 2; corrupt_en = 1; corrupt_addr = 16'h1042;
    run(16'h1040, 8'd5, 3, cyc);
    chk(err && err_code == 2'b10, "R5 verify error code", err_code, 2);
    chk(err_addr == 16'h1042, "R5 failing address", err_addr, 16'h1042);
    chk(prog_cnt == 3, "R5 run stops at failure", prog_cnt, 3);
    chk(exp_q.size() == 0, "R5 writes up to failure", exp_q.size(), 0);
    repeat (10) @(negedge clk);
    chk(err && err_code == 2'b10 && !busy, "R9 error held while idle", {err, err_code}, 3'b110);
    corrupt_en = 0;
    clear_model();

    // T5: device never completes
    busy_cfg = 1000;
    run(16'h1080, 8'd2, 1, cyc);
    chk(!err_after_start, "R9 start clears error", err_after_start, 0);
    chk(err && err_code == 2'b01, "R6 timeout code", err_code, 1);
    chk(err_addr == 16'h1080, "R6 timeout address", err_addr, 16'h1080);
    chk(rd_cnt == MAXP, "R6 poll count at timeout", rd_cnt, MAXP);
    clear_model();

    // T6: start while busy is ignored
    for (int i = 0; i < 256; i++) src[i] = 8'(255 - i * 7);
    busy_cfg = 1;
    begin
      bit busy_mid;
      busy_mid = 0;
      fork
        run(16'h10A0, 8'd3, 3, cyc);
        begin
          repeat (30) @(negedge clk);
          busy_mid = busy;
          start = 1; base = 16'h2000; len = 8'd1;
          @(negedge clk) start = 0;
        end
      join
      chk(busy_mid, "R8 busy during run", busy_mid, 1);
    end
    chk(!err && prog_cnt == 3, "R9 start while busy ignored", prog_cnt, 3);
    for (int i = 0; i < 3; i++)
      chk(fmem[8'hA0 + i] == src[i], "R9 stored byte", fmem[8'hA0 + i], src[i]);
    repeat (20) @(negedge clk);
    chk(!busy && wr_cnt == 12, "R9 no extra run started", wr_cnt, 12);
    chk(exp_q.size() == 0, "R7 scoreboard drained", exp_q.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end
endmodule